// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block keeps a free-running 64-bit time base and raises one interrupt when that time base reaches a programmed value. The count advances by one on every third cycle of the input clock. An internal tick enable sets that rate, so no second clock domain is needed. Software reaches the block over a simple 32-bit memory-mapped bus with single-cycle requests. It reads the count as a low word and a high word, loads a compare value, and controls the compare channel through a control register.

The compare value is 52 bits wide. The low word carries 32 bits, and only the bottom 20 bits of the high word are stored. While the channel is enabled, the block compares the count against the stored value on every cycle. Once the count is equal to or past that value, a status flag sets and stays set. The interrupt output follows the status flag unless the mask bit is set. To acknowledge the interrupt, software clears the enable bit; this also clears the status flag.

To read the full count without tearing, software reads the high word, then the low word, then the high word again. If the two high values differ, it repeats the sequence. The count reset value is a parameter so that a low-word carry can be reached quickly. It defaults to zero.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset, the control register reads 0, both compare words read 0, the interrupt is low, and read-valid is low. The count holds the reset value `CNT_INIT` (default 0) until the first tick.
- R2: The count increases by exactly one on every third clock edge after reset is released. The first increment happens on the third edge.
- R3: A read request at address 0x8 returns count bits 31:0, and a request at 0xC returns count bits 63:32. The data and read-valid appear in the cycle after the request. They show the count as it stood when the request was sampled.
- R4: A carry from count bit 31 into bit 32 is visible between reads. A high/low/high read sequence that spans the carry returns the old high word and then the new one.
- R5: The compare low word is at 0x10020 and the compare high word is at 0x10024. Both read back. Only bits 19:0 of the high word are stored, and bits 31:20 read as 0. A 52-bit compare value that spans both words is honoured.
- R6: The control register is at 0x1002C. Bit 0 is enable, bit 1 is the interrupt mask, and bit 2 is the status flag. All other bits read as 0.
- R7: While enable is 1, status sets on the edge after the count is first greater than or equal to the compare value. It then stays set for as long as enable stays 1.
- R8: A write that clears enable also clears status on the same edge. The interrupt is low from the cycle after that write.
- R9: The interrupt output is high exactly when status is 1 and the mask bit is 0. Changing the mask does not change status.
- R10: Reads from unmapped addresses return 0. Writes to the count addresses or to unmapped addresses change no state.
- R11: A write to control bit 2 is ignored. Status cannot be set by software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| bus_valid | input | 1 | Single-cycle request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 20 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read request |
| bus_rvalid | output | 1 | High in the cycle that carries read data |
| irq | output | 1 | Compare interrupt, active high |

## Verification
On every cycle the assertions check the following:
- The count moves only in single steps, and only after a tick.
- Ticks never come back to back.
- Read-valid follows each read request by one cycle.
- Status is never set while enable is clear, and it drops when enable falls.
- Status sets once an enabled channel has seen the count at or past the compare value.
- The interrupt equals status with the mask applied.

Other behaviours can only be shown by the bench's scenarios. These are the register addresses and field positions, the truncation of the compare high word, the exact cycle of the first tick, the carry seen through high/low/high reads, and the fact that writes to read-only or unmapped locations change nothing.

// File: rtl/tct_pkg.sv
package tct_pkg;
  localparam int BUS_AW = 20;
  localparam int BUS_DW = 32;

  // Register map (byte addresses); software depends on these offsets.
  localparam logic [BUS_AW-1:0] ADDR_CNT_LO = 20'h00008;
  localparam logic [BUS_AW-1:0] ADDR_CNT_HI = 20'h0000C;
  localparam logic [BUS_AW-1:0] ADDR_CMP_LO = 20'h10020;
  localparam logic [BUS_AW-1:0] ADDR_CMP_HI = 20'h10024;
  localparam logic [BUS_AW-1:0] ADDR_CTRL   = 20'h1002C;

  // Control register bit positions
  localparam int CTL_EN   = 0;
  localparam int CTL_MASK = 1;
  localparam int CTL_STAT = 2;
endpackage

// File: rtl/tct_prescale.sv
module tct_prescale #(
  parameter int DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_bypass
      assign tick = 1'b1;
    end else begin : g_div
      logic [PH_W-1:0] phase_q, phase_d;

      assign tick = (phase_q == PH_W'(DIV - 1));

      always_comb begin
        phase_d = tick ? '0 : phase_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
      end
    end
  endgenerate
endmodule

// File: rtl/tct_counter.sv
module tct_counter #(
  parameter int          CNT_W    = 64,
  parameter logic [63:0] CNT_INIT = 64'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_INIT[CNT_W-1:0];
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tct_compare.sv
module tct_compare #(
  parameter int CNT_W = 64,
  parameter int CMP_W = 52
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_next,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CMP_W-1:0] cmp,
  output logic             status_q
);
  localparam int PAD_W = CNT_W - CMP_W;

  logic             status_d;
  logic             reached;
  logic [CNT_W-1:0] cmp_ext;

  assign cmp_ext = {{PAD_W{1'b0}}, cmp};
  // Greater-or-equal so a compare value already passed still fires.
  assign reached = (cnt >= cmp_ext);

  always_comb begin
    status_d = en_next & (status_q | reached);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= 1'b0;
    else        status_q <= status_d;
  end
endmodule

// File: rtl/tct_regs.sv
module tct_regs
  import tct_pkg::*;
#(
  parameter int CNT_W    = 64,
  parameter int CMP_HI_W = 20,
  parameter int CMP_W    = BUS_DW + CMP_HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              status,
  output logic              en_q,
  output logic              en_next,
  output logic              mask_q,
  output logic [CMP_W-1:0]  cmp_q
);
  logic                wr, rd;
  logic                sel_cnt_lo, sel_cnt_hi, sel_cmp_lo, sel_cmp_hi, sel_ctrl;
  logic [BUS_DW-1:0]   cmp_lo_q, cmp_lo_d;
  logic [CMP_HI_W-1:0] cmp_hi_q, cmp_hi_d;
  logic                mask_d;
  logic [BUS_DW-1:0]   rdata_d;
  logic                rvalid_d;

  assign wr = bus_valid &  bus_write;
  assign rd = bus_valid & ~bus_write;

  assign sel_cnt_lo = (bus_addr == ADDR_CNT_LO);
  assign sel_cnt_hi = (bus_addr == ADDR_CNT_HI);
  assign sel_cmp_lo = (bus_addr == ADDR_CMP_LO);
  assign sel_cmp_hi = (bus_addr == ADDR_CMP_HI);
  assign sel_ctrl   = (bus_addr == ADDR_CTRL);

  // Next-state for writable fields
  always_comb begin
    cmp_lo_d = cmp_lo_q;
    cmp_hi_d = cmp_hi_q;
    en_next  = en_q;
    mask_d   = mask_q;
    if (wr && sel_cmp_lo) cmp_lo_d = bus_wdata;
    if (wr && sel_cmp_hi) cmp_hi_d = bus_wdata[CMP_HI_W-1:0];
    if (wr && sel_ctrl) begin
      en_next = bus_wdata[CTL_EN];
      mask_d  = bus_wdata[CTL_MASK];
    end
  end

  // Read mux; unmapped addresses yield zero
  always_comb begin
    rdata_d  = '0;
    rvalid_d = rd;
    if (rd) begin
      if (sel_cnt_lo) rdata_d = cnt[BUS_DW-1:0];
      if (sel_cnt_hi) rdata_d = BUS_DW'(cnt[CNT_W-1:BUS_DW]);
      if (sel_cmp_lo) rdata_d = cmp_lo_q;
      if (sel_cmp_hi) rdata_d = BUS_DW'(cmp_hi_q);
      if (sel_ctrl) begin
        rdata_d[CTL_EN]   = en_q;
        rdata_d[CTL_MASK] = mask_q;
        rdata_d[CTL_STAT] = status;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_lo_q   <= '0;
      cmp_hi_q   <= '0;
      en_q       <= 1'b0;
      mask_q     <= 1'b0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      cmp_lo_q   <= cmp_lo_d;
      cmp_hi_q   <= cmp_hi_d;
      en_q       <= en_next;
      mask_q     <= mask_d;
      bus_rdata  <= rdata_d;
      bus_rvalid <= rvalid_d;
    end
  end

  assign cmp_q = {cmp_hi_q, cmp_lo_q};
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
  import tct_pkg::*;
#(
  parameter int          CNT_W    = 64,
  parameter int          CMP_HI_W = 20,
  parameter int          DIV      = 3,
  parameter logic [63:0] CNT_INIT = 64'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              irq
);
  localparam int CMP_W = BUS_DW + CMP_HI_W;

  // rst_n is expected to be released synchronously by the reset tree.
  logic             tick;
  logic [CNT_W-1:0] cnt_q;
  logic             en_q, en_next, mask_q, status_q;
  logic [CMP_W-1:0] cmp_q;

  tct_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  tct_counter #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_q(cnt_q)
  );

  tct_regs #(.CNT_W(CNT_W), .CMP_HI_W(CMP_HI_W), .CMP_W(CMP_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .cnt(cnt_q), .status(status_q),
    .en_q(en_q), .en_next(en_next), .mask_q(mask_q), .cmp_q(cmp_q)
  );

  tct_compare #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .en_next(en_next),
    .cnt(cnt_q), .cmp(cmp_q), .status_q(status_q)
  );

  assign irq = status_q & ~mask_q;
endmodule

// File: rtl/tct_checker.sv
module tct_checker #(
  parameter int CNT_W = 64,
  parameter int CMP_W = 52,
  parameter int DIV   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CMP_W-1:0] cmp,
  input logic             en_q,
  input logic             mask_q,
  input logic             status,
  input logic             irq,
  input logic             bus_valid,
  input logic             bus_write,
  input logic             bus_rvalid
);
  logic at_or_past;
  assign at_or_past = (cnt >= {{(CNT_W-CMP_W){1'b0}}, cmp});

  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1));

  p_step_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick) |-> (cnt == $past(cnt) + 1'b1));

  generate
    if (DIV > 1) begin : g_gap
      p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tick) |-> !tick);
    end
  endgenerate

  p_rvalid_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid == $past(bus_valid && !bus_write));

  p_status_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    status |-> en_q);

  p_status_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(at_or_past)) |-> status);

  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> !status);

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (status && !mask_q));
endmodule

bind tick_cmp_timer tct_checker #(.CNT_W(CNT_W), .CMP_W(CMP_W), .DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt_q), .cmp(cmp_q),
  .en_q(en_q), .mask_q(mask_q), .status(status_q), .irq(irq),
  .bus_valid(bus_valid), .bus_write(bus_write), .bus_rvalid(bus_rvalid)
);

// File: tb/tick_cmp_timer_tb.sv
module tick_cmp_timer_tb;
  import tct_pkg::*;

  localparam int          CLK_PERIOD = 10;
  localparam logic [63:0] INIT       = 64'h0000_0000_FFFF_FFA0;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_valid = 1'b0;
  logic              bus_write = 1'b0;
  logic [BUS_AW-1:0] bus_addr = '0;
  logic [BUS_DW-1:0] bus_wdata = '0;
  logic [BUS_DW-1:0] bus_rdata;
  logic              bus_rvalid;
  logic              irq;

  tick_cmp_timer #(.CNT_INIT(INIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Edges since reset release
  longint cyc = 0;
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // Reference model of software-visible state
  bit          m_en = 0, m_mask = 0;
  longint      m_en_edge = 0;
  logic [63:0] m_cmp = '0;

  function automatic logic [63:0] cnt_at(longint n);
    return INIT + 64'(n / 3);
  endfunction

  function automatic bit stat_after(longint c);
    return m_en && (c >= m_en_edge) && (cnt_at(c - 1) >= m_cmp);
  endfunction

  function automatic logic [31:0] exp_read(logic [BUS_AW-1:0] a, longint c);
    logic [63:0] v;
    v = cnt_at(c);
    case (a)
      ADDR_CNT_LO: return v[31:0];
      ADDR_CNT_HI: return v[63:32];
      ADDR_CMP_LO: return m_cmp[31:0];
      ADDR_CMP_HI: return m_cmp[63:32];
      ADDR_CTRL:   return {29'b0, stat_after(c), m_mask, m_en};
      default:     return 32'h0;
    endcase
  endfunction

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Driver: issue a read and push the expected data
  task automatic do_read(logic [BUS_AW-1:0] a, string tag);
    exp_t e;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    e.val = exp_read(a, cyc);
    e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic do_write(logic [BUS_AW-1:0] a, logic [31:0] d);
    longint c;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    c = cyc;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    case (a)
      ADDR_CMP_LO: m_cmp[31:0]  = d;
      ADDR_CMP_HI: m_cmp[63:32] = {12'b0, d[19:0]};
      ADDR_CTRL: begin
        if (d[0] && !m_en) m_en_edge = c + 1;
        m_en   = d[0];
        m_mask = d[1];
      end
      default: ;
    endcase
  endtask

  task automatic check_irq(string tag);
    bit e;
    e = stat_after(cyc) && !m_mask;
    check(irq === e, tag, 64'(irq), 64'(e));
  endtask

  // Monitor: compare read data against the scoreboard
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R3 unexpected read-valid", 64'(bus_rdata), 64'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(bus_rdata === e.val, e.tag, 64'(bus_rdata), 64'(e.val));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] tgt;
    repeat (3) @(negedge clk);
    check(irq === 1'b0, "R1 irq during reset", 64'(irq), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_rvalid === 1'b0, "R1 rvalid after reset", 64'(bus_rvalid), 64'h0);
    check(irq === 1'b0, "R1 irq after reset", 64'(irq), 64'h0);

    // R1 reset contents
    do_read(ADDR_CTRL,   "R1 ctrl reset");
    do_read(ADDR_CMP_LO, "R1 cmp lo reset");
    do_read(ADDR_CMP_HI, "R1 cmp hi reset");
    do_read(ADDR_CNT_HI, "R1 count hi reset");

    // R2/R3 cadence via back-to-back low reads
    for (int i = 0; i < 6; i++) do_read(ADDR_CNT_LO, "R2 R3 count lo cadence");

    // R10 unmapped and read-only
    do_read(20'h00000, "R10 unmapped 0x0");
    do_read(20'h10028, "R10 unmapped 0x10028");
    do_write(ADDR_CNT_LO, 32'h0000_0000);
    do_write(20'h00010, 32'hFFFF_FFFF);
    do_read(ADDR_CNT_LO, "R10 count unaffected by write");
    do_read(ADDR_CTRL,   "R10 ctrl unaffected by stray write");

    // R5 compare words, high truncated to 20 bits
    do_write(ADDR_CMP_HI, 32'hFFFF_FFFF);
    do_read(ADDR_CMP_HI, "R5 cmp hi truncation");
    do_write(ADDR_CMP_LO, 32'h1234_5678);
    do_read(ADDR_CMP_LO, "R5 cmp lo readback");

    // R6/R7 enable with a far compare: no status
    do_write(ADDR_CTRL, 32'h1);
    repeat (6) @(negedge clk);
    do_read(ADDR_CTRL, "R6 R7 enabled, not reached");
    check_irq("R7 irq low before reach");
    do_write(ADDR_CTRL, 32'h0);

    // R7/R11 near compare; write status bit too
    tgt = cnt_at(cyc) + 64'd8;
    do_write(ADDR_CMP_HI, tgt[63:32]);
    do_write(ADDR_CMP_LO, tgt[31:0]);
    do_write(ADDR_CTRL, 32'h5);
    do_read(ADDR_CTRL, "R11 status bit write ignored");
    for (int i = 0; i < 14; i++) begin
      do_read(ADDR_CTRL, "R7 status edge");
      check_irq("R7 R9 irq follows status");
    end
    check(irq === 1'b1, "R7 irq raised after reach", 64'(irq), 64'h1);

    // R9 mask
    do_write(ADDR_CTRL, 32'h3);
    check_irq("R9 irq masked");
    do_read(ADDR_CTRL, "R9 status kept while masked");
    do_write(ADDR_CTRL, 32'h1);
    check_irq("R9 irq unmasked");

    // R8 acknowledge
    do_write(ADDR_CTRL, 32'h0);
    check_irq("R8 irq drops after clearing enable");
    do_read(ADDR_CTRL, "R8 status cleared");
    do_write(ADDR_CTRL, 32'h4);
    do_read(ADDR_CTRL, "R11 status not set by software");

    // R5/R4 compare across both words, carry through high/low/high reads
    do_write(ADDR_CMP_HI, 32'h1);
    do_write(ADDR_CMP_LO, 32'h10);
    do_write(ADDR_CTRL, 32'h1);
    while (cyc < 272) @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      do_read(ADDR_CNT_HI, "R4 high before low");
      do_read(ADDR_CNT_LO, "R4 low");
      do_read(ADDR_CNT_HI, "R4 high after low");
    end
    while (cyc < 350) begin
      do_read(ADDR_CTRL, "R5 R7 52-bit compare");
      check_irq("R5 R9 irq on 52-bit compare");
    end
    check(irq === 1'b1, "R5 52-bit compare fired", 64'(irq), 64'h1);

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R3 all reads returned", 64'(sb_q.size()), 64'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule